// File: doc/BRIEF.md
# Dual-Enable Memory Bus Front End

This block sits between an external byte-wide memory bus and the internal logic of a memory that holds two storage blocks, an EEPROM block and a flash block, each with its own active-low block enable. It samples the asynchronous bus controls (the two block enables, the output enable and the write enable) with the system clock. From them it works out whether the bus is reading, writing, idle or in an illegal state, and it presents clean, clock-aligned results to the array logic behind it.

For writes it captures the address when the write window opens, which is the later of the enable falling and the write enable falling. It captures the data when the window closes, which is the earlier of the two rising. It then issues a one-cycle write strobe tagged with the target block. For reads it enables the data output only while exactly one block is selected and the output enable is low. It also reports standby when neither block is selected and no internal operation runs. A pseudo-standby flag rises after a run of idle cycles while a block stays selected, and the bus keeps being driven during it. Selecting both blocks at once raises a conflict flag. That access is then dropped until both enables are released.

Top module: `membus_front`

## Requirements
- R1: With exactly one block enable low and the output enable low, `dq_oe_o` is 1 and `dq_o` equals `rdata_i`, three clock cycles after the controls change.
- R2: When the output enable is high or both block enables are high, `dq_oe_o` is 0 and `dq_o` is 0.
- R3: A write window is open while exactly one enable is low, the write enable is low and the output enable is high. `wr_addr_o` takes the bus address present when the window opens, which is the later of the two falling edges. Later address changes do not alter it.
- R4: When the window closes (the earlier of the two rising edges), `wr_data_o` takes the bus data present at that edge. `wr_strobe_o` pulses for exactly one cycle. Data changed after that edge is not captured.
- R5: `wr_blk_o` and `rd_blk_o` are 1 for the flash block (selected by `ef_n_i`) and 0 for the EEPROM block (selected by `ee_n_i`). For the EEPROM block only address bits 12:0 are kept, and bits 17:13 of `wr_addr_o` read 0.
- R6: While both enables are low, `conflict_o` is 1, nothing is driven and no write strobe is issued. An access interrupted this way stays ignored until both enables have been high.
- R7: `standby_o` is 1 when both enables are high and `busy_i` is 0, whatever the output and write enables do. It is 0 while `busy_i` is 1.
- R8: If a block stays selected with no change on the controls or the address for `IDLE_CYCLES` cycles, `lowpwr_o` rises and the read drive continues. Any change clears it within three cycles. In standby `lowpwr_o` stays 0.
- R9: After reset `dq_oe_o`, `wr_strobe_o` and `conflict_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ee_n_i | input | 1 | EEPROM block enable, active low, asynchronous |
| ef_n_i | input | 1 | Flash block enable, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | 18 | Bus address |
| wdata_i | input | 8 | Bus write data |
| rdata_i | input | 8 | Read data from the array |
| busy_i | input | 1 | Internal program, erase or write in progress |
| wr_addr_o | output | 18 | Captured write address, masked for the EEPROM block |
| wr_data_o | output | 8 | Captured write data |
| wr_blk_o | output | 1 | Write target block, 1 for flash |
| wr_strobe_o | output | 1 | One-cycle write request |
| rd_blk_o | output | 1 | Block being read, 1 for flash |
| dq_o | output | 8 | Data to the bus pads |
| dq_oe_o | output | 1 | Pad output enable |
| conflict_o | output | 1 | Both block enables low |
| standby_o | output | 1 | Standby state |
| lowpwr_o | output | 1 | Automatic pseudo-standby state |

## Verification
Each control input crosses two synchroniser flops and one output register. So every bus-facing result (the read drive, the conflict flag, the captured address and the strobe) appears three clock edges after the input change. The only exception is `standby_o`'s reaction to `busy_i`, which takes one edge. The bench changes inputs on falling clock edges and samples on the falling edge three cycles later. Write strobes are not polled at a fixed time: expected write items go into a queue, and a monitor compares each strobe whenever it fires. The idle flag is checked at a point well past its threshold and again three cycles after an address change.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic {
    BLK_EEPROM = 1'b0,
    BLK_FLASH  = 1'b1
  } blk_e;

  // exactly one of two active-low selects is asserted
  function automatic logic one_selected(input logic a_n, input logic b_n);
    return a_n ^ b_n;
  endfunction

  // both active-low selects asserted: illegal
  function automatic logic both_selected(input logic a_n, input logic b_n);
    return !a_n && !b_n;
  endfunction

  function automatic blk_e pick_block(input logic ef_n);
    return ef_n ? BLK_EEPROM : BLK_FLASH;
  endfunction

endpackage

// File: rtl/membus_pipe.sv
module membus_pipe #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/membus_wrcap.sv
module membus_wrcap
  import membus_pkg::*;
#(
  parameter int AW    = 18,
  parameter int EE_AW = 13,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_ee_n,
  input  logic          s_ef_n,
  input  logic          s_oe_n,
  input  logic          s_we_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_blk,
  output logic          wr_strobe,
  output logic          poisoned,
  output logic          win_open,
  output logic          win_close
);
  logic win_now, win_q, clash, released;

  function automatic logic [AW-1:0] mask_addr(input logic [AW-1:0] a, input blk_e b);
    logic [AW-1:0] m;
    m = '0;
    m[EE_AW-1:0] = '1;
    return (b == BLK_FLASH) ? a : (a & m);
  endfunction

  assign clash    = both_selected(s_ee_n, s_ef_n);
  assign released = s_ee_n && s_ef_n;
  assign win_now  = one_selected(s_ee_n, s_ef_n) && !s_we_n && s_oe_n && !poisoned && !clash;
  assign win_open  = win_now && !win_q;
  assign win_close = !win_now && win_q && !clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= 1'b0;
      poisoned  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_blk    <= 1'b0;
      wr_strobe <= 1'b0;
    end else begin
      win_q     <= win_now;
      wr_strobe <= win_close;
      if (clash)         poisoned <= 1'b1;
      else if (released) poisoned <= 1'b0;
      if (win_open) begin
        wr_blk  <= pick_block(s_ef_n);
        wr_addr <= mask_addr(a_addr, pick_block(s_ef_n));
      end
      if (win_close) wr_data <= a_data;
    end
  end
endmodule

// File: rtl/membus_idle.sv
module membus_idle #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic idle
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (activity) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;

  assign idle = (cnt == TOP);
endmodule

// File: rtl/membus_front.sv
module membus_front
  import membus_pkg::*;
#(
  parameter int AW          = 18,
  parameter int EE_AW       = 13,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ee_n_i,
  input  logic          ef_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          busy_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_blk_o,
  output logic          wr_strobe_o,
  output logic          rd_blk_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          conflict_o,
  output logic          standby_o,
  output logic          lowpwr_o
);
  localparam int CTL_W = 4;

  logic [CTL_W-1:0] ctl_s, ctl_prev;
  logic [AW-1:0]    addr_a, addr_prev;
  logic [DW-1:0]    data_a;
  logic s_ee_n, s_ef_n, s_oe_n, s_we_n;
  logic rd_now, clash_now, activity, idle, poisoned;
  logic win_open, win_close;

  membus_pipe #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ctl_sync (
    .clk, .rst_n, .d({ee_n_i, ef_n_i, oe_n_i, we_n_i}), .q(ctl_s));

  // address and data are delayed by the same depth so they line up with the controls
  membus_pipe #(.W(AW + DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_align (
    .clk, .rst_n, .d({addr_i, wdata_i}), .q({addr_a, data_a}));

  assign {s_ee_n, s_ef_n, s_oe_n, s_we_n} = ctl_s;

  membus_wrcap #(.AW(AW), .EE_AW(EE_AW), .DW(DW)) u_wrcap (
    .clk, .rst_n,
    .s_ee_n, .s_ef_n, .s_oe_n, .s_we_n,
    .a_addr(addr_a), .a_data(data_a),
    .wr_addr(wr_addr_o), .wr_data(wr_data_o), .wr_blk(wr_blk_o),
    .wr_strobe(wr_strobe_o), .poisoned,
    .win_open, .win_close);

  assign clash_now = both_selected(s_ee_n, s_ef_n);
  assign rd_now    = one_selected(s_ee_n, s_ef_n) && !s_oe_n && !poisoned;
  assign activity  = (ctl_s != ctl_prev) || (addr_a != addr_prev);

  membus_idle #(.LIMIT(IDLE_CYCLES)) u_idle (
    .clk, .rst_n, .activity, .idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_prev   <= '1;
      addr_prev  <= '0;
      dq_oe_o    <= 1'b0;
      dq_o       <= '0;
      rd_blk_o   <= 1'b0;
      conflict_o <= 1'b0;
      standby_o  <= 1'b0;
    end else begin
      ctl_prev   <= ctl_s;
      addr_prev  <= addr_a;
      dq_oe_o    <= rd_now;
      dq_o       <= rd_now ? rdata_i : '0;
      if (rd_now) rd_blk_o <= pick_block(s_ef_n);
      conflict_o <= clash_now;
      standby_o  <= s_ee_n && s_ef_n && !busy_i;
    end
  end

  assign lowpwr_o = idle && !standby_o;
endmodule

// File: rtl/membus_front_chk.sv
module membus_front_chk #(
  parameter int AW    = 18,
  parameter int EE_AW = 13,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_blk_o,
  input logic          wr_strobe_o,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o,
  input logic          conflict_o,
  input logic          standby_o,
  input logic          lowpwr_o
);
  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> (!dq_oe_o && dq_o == '0));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> !wr_strobe_o);

  p_eeprom_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_o && !wr_blk_o) |-> (wr_addr_o[AW-1:EE_AW] == '0));

  p_conflict_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> (!dq_oe_o && !wr_strobe_o));

  p_lowpwr_not_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr_o |-> !standby_o);
endmodule

bind membus_front membus_front_chk #(.AW(AW), .EE_AW(EE_AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_addr_o(wr_addr_o), .wr_blk_o(wr_blk_o),
  .wr_strobe_o(wr_strobe_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
  .conflict_o(conflict_o), .standby_o(standby_o), .lowpwr_o(lowpwr_o));

// File: tb/tb_membus_front.sv
module tb_membus_front;
  localparam int AW = 18, DW = 8, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ee_n = 1'b1, ef_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata = '0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, dq;
  logic wr_blk, wr_strobe, rd_blk, dq_oe, conflict, standby, lowpwr;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic b; string req; } wr_item_t;
  wr_item_t expq[$];

  always #10 clk = ~clk;

  membus_front dut (
    .clk, .rst_n, .ee_n_i(ee_n), .ef_n_i(ef_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_i(rdata), .busy_i(busy),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_blk_o(wr_blk),
    .wr_strobe_o(wr_strobe), .rd_blk_o(rd_blk), .dq_o(dq), .dq_oe_o(dq_oe),
    .conflict_o(conflict), .standby_o(standby), .lowpwr_o(lowpwr));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b, input string req);
    wr_item_t it;
    it.a = a; it.d = d; it.b = b; it.req = req;
    expq.push_back(it);
  endtask

  // monitor: each strobe must match the oldest expected write
  always @(negedge clk) begin
    if (rst_n && wr_strobe && !finished) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected strobe", 32'(wr_addr), 32'h0);
      end else begin
        wr_item_t it;
        it = expq.pop_front();
        check(wr_addr == it.a, {it.req, " addr"}, 32'(wr_addr), 32'(it.a));
        check(wr_data == it.d, {it.req, " data"}, 32'(wr_data), 32'(it.d));
        check(wr_blk == it.b, {it.req, " block"}, 32'(wr_blk), 32'(it.b));
      end
    end
  end

  task automatic summary;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R9 reset state
    check(!dq_oe && !wr_strobe && !conflict, "R9 reset outputs", {dq_oe, wr_strobe, conflict}, 0);
    tick(LAT);

    // R3/R4/R5 flash write: address at later falling edge, data at earlier rising edge
    addr = 18'h2_1234; ef_n = 1'b0; tick(1);
    addr = 18'h3_0F0F; tick(1);
    we_n = 1'b0; tick(LAT);
    check(wr_addr == 18'h3_0F0F, "R3 later falling edge addr", 32'(wr_addr), 32'h30F0F);
    addr = 18'h0_0001; wdata = 8'h5A; tick(2);
    expect_write(18'h3_0F0F, 8'h5A, 1'b1, "R4 flash write");
    ef_n = 1'b1; tick(1);
    wdata = 8'hFF; tick(1);
    we_n = 1'b1; tick(LAT + 2);
    check(expq.size() == 0, "R4 flash strobe seen", expq.size(), 0);

    // R5 EEPROM write: upper address bits dropped, write enable rises first
    addr = 18'h3_FABC; ee_n = 1'b0; tick(1);
    we_n = 1'b0; wdata = 8'h11; tick(LAT);
    expect_write(18'h0_1ABC, 8'h11, 1'b0, "R5 eeprom write");
    we_n = 1'b1; tick(1);
    wdata = 8'h22; tick(LAT);
    ee_n = 1'b1; tick(LAT + 1);
    check(expq.size() == 0, "R5 eeprom strobe seen", expq.size(), 0);

    // R6 conflict: both enables low during a write, no strobe, no drive
    ef_n = 1'b0; we_n = 1'b0; addr = 18'h1_0000; tick(2);
    ee_n = 1'b0; tick(LAT);
    check(conflict == 1'b1, "R6 conflict flag", conflict, 1);
    check(dq_oe == 1'b0, "R6 no drive in conflict", dq_oe, 0);
    ee_n = 1'b1; tick(LAT);
    check(conflict == 1'b0, "R6 conflict clears", conflict, 0);
    we_n = 1'b1; tick(LAT);
    ef_n = 1'b1; tick(LAT + 2);
    oe_n = 1'b0; ef_n = 1'b0; ee_n = 1'b0; tick(LAT);
    check(dq_oe == 1'b0, "R6 read blocked", dq_oe, 0);
    ee_n = 1'b1; tick(LAT);
    check(dq_oe == 1'b0, "R6 stays ignored until release", dq_oe, 0);
    ef_n = 1'b1; oe_n = 1'b1; tick(LAT + 2);

    // R1/R2/R5 reads
    rdata = 8'hC3; ef_n = 1'b0; oe_n = 1'b0; tick(LAT);
    check(dq_oe && dq == 8'hC3, "R1 flash read drive", {dq_oe, dq}, 9'h1C3);
    check(rd_blk == 1'b1, "R5 read block flash", rd_blk, 1);
    oe_n = 1'b1; tick(LAT);
    check(!dq_oe && dq == 8'h00, "R2 output enable high", {dq_oe, dq}, 0);
    ef_n = 1'b1; tick(LAT);
    ee_n = 1'b0; oe_n = 1'b0; rdata = 8'h3C; tick(LAT);
    check(dq_oe && dq == 8'h3C, "R1 eeprom read drive", {dq_oe, dq}, 9'h13C);
    check(rd_blk == 1'b0, "R5 read block eeprom", rd_blk, 0);

    // R7 standby with output and write enables low
    ee_n = 1'b1; we_n = 1'b0; tick(LAT);
    check(standby == 1'b1, "R7 standby", standby, 1);
    check(!dq_oe, "R2 no drive in standby", dq_oe, 0);
    busy = 1'b1; tick(1);
    check(standby == 1'b0, "R7 busy blocks standby", standby, 0);
    busy = 1'b0; we_n = 1'b1; tick(2);

    // R8 pseudo-standby while reading
    ef_n = 1'b0; oe_n = 1'b0; rdata = 8'h77; tick(LAT);
    check(lowpwr == 1'b0, "R8 not idle after activity", lowpwr, 0);
    tick(20);
    check(lowpwr == 1'b1, "R8 idle flag", lowpwr, 1);
    check(dq_oe && dq == 8'h77, "R8 drive kept", {dq_oe, dq}, 9'h177);
    addr = 18'h0_0555; tick(LAT);
    check(lowpwr == 1'b0, "R8 cleared by address change", lowpwr, 0);
    ef_n = 1'b1; oe_n = 1'b1; tick(25);
    check(lowpwr == 1'b0 && standby, "R8 not in standby", {lowpwr, standby}, 2'b01);

    tick(2);
    check(expq.size() == 0, "R4 queue empty at end", expq.size(), 0);
    summary();
  end
endmodule